// File: doc/BRIEF.md
# Control Read Transfer Sequencer

This block follows one control read transfer on the default endpoint of a USB device, from the moment the SETUP arrives until the host finishes the status stage. The data stage is sent as a series of IN packets. For each packet the block gives the byte count to load and says whether the packet is the terminating zero-length packet. When the host acknowledges a packet and bytes are still left, the block raises a one-cycle request so that local firmware refills the endpoint FIFO. After the data stage it waits for the host's empty OUT packet, which completes the transfer.

The data length is the smaller of the host's requested length and the length the device has to return. A zero-length packet is added only when the device returns less than was asked for and the last data packet was full-sized. At any moment the host may send a new SETUP. When it does, the block drops what it was doing and starts over from the new request. An IN token that arrives after the data stage is over is reported as a protocol error.

Top module: `ctrl_rd_seq`

## Requirements
- R1: While reset is held and after it is released, `stage` reads IDLE (0), and `pkt_len`, `zlp`, `refill_req` and `proto_err` are 0. `pkt_len` and `zlp` are 0 in every stage other than DATA.
- R2: A `setup_evt` with a nonzero effective length moves `stage` to DATA (1) in the next cycle. `pkt_len` then shows the smaller of the effective length and `max_pkt`.
- R3: The effective length is `ret_len` when `ret_len` is below `req_len`, and `req_len` otherwise.
- R4: An IN in DATA that the host does not acknowledge (`in_evt` with `in_ack`=0) changes neither `stage` nor `pkt_len`, and raises no `refill_req`.
- R5: An acknowledged IN in DATA removes `pkt_len` bytes from the remaining count. When bytes still remain, `refill_req` is 1 for exactly the following cycle.
- R6: An acknowledged packet shorter than `max_pkt` ends the data stage. `stage` becomes STATUS (2) and no `refill_req` is raised.
- R7: When `ret_len` is below `req_len` and the last data packet was full-sized, the next packet has `zlp`=1 and `pkt_len`=0. Acknowledging that packet moves `stage` to STATUS.
- R8: When the effective length equals `req_len` and is a multiple of `max_pkt`, acknowledging the last full packet moves `stage` straight to STATUS, with no zero-length packet.
- R9: A `setup_evt` whose effective length is 0 moves `stage` straight to STATUS.
- R10: In STATUS, an `out_evt` with `out_zero`=1 moves `stage` to DONE (3). An OUT with data in STATUS is ignored, and so is any OUT in DATA.
- R11: A `setup_evt` in any stage reloads the counts from the new request, even in the middle of the data stage.
- R12: An `in_evt` in STATUS or DONE raises `proto_err` for exactly the next cycle and leaves `stage` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| setup_evt | input | 1 | SETUP packet received (one-cycle pulse) |
| req_len | input | LEN_W | Length requested by the host in the SETUP |
| ret_len | input | LEN_W | Length the device has to return |
| max_pkt | input | MPS_W | Maximum packet size of the endpoint (nonzero) |
| in_evt | input | 1 | IN transaction finished (one-cycle pulse) |
| in_ack | input | 1 | The finished IN was acknowledged by the host |
| out_evt | input | 1 | OUT transaction with data phase received (one-cycle pulse) |
| out_zero | input | 1 | The OUT data payload was empty |
| pkt_len | output | MPS_W | Byte count of the next IN packet |
| zlp | output | 1 | The next IN packet is the terminating zero-length packet |
| refill_req | output | 1 | Request to refill the endpoint FIFO (one-cycle pulse) |
| stage | output | 2 | Transfer stage: IDLE=0, DATA=1, STATUS=2, DONE=3 |
| proto_err | output | 1 | An IN arrived after the data stage had ended (one-cycle pulse) |

## Verification
The hardest state to reach is the pending zero-length packet. Getting there needs a returned length below the requested one that is also an exact multiple of the packet size, and every full packet before it must be acknowledged. The stimulus builds that case and compares it with two near misses: a returned length equal to the request, and a returned length that ends on a short packet. It also interrupts a data stage partway through with a new SETUP that uses a different packet size, and checks that the new counts replace the old ones.

// File: rtl/ctrl_rd_pkg.sv
package ctrl_rd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DATA   = 2'd1,
    ST_STATUS = 2'd2,
    ST_DONE   = 2'd3
  } stage_t;
endpackage

// File: rtl/ctrl_rd_rst_sync.sv
module ctrl_rd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/ctrl_rd_pktsize.sv
module ctrl_rd_pktsize #(
  parameter int LEN_W = 16,
  parameter int MPS_W = 7
) (
  input  logic             active,
  input  logic [LEN_W-1:0] remain,
  input  logic [MPS_W-1:0] mps,
  output logic [MPS_W-1:0] pkt_len,
  output logic             zlp,
  output logic             last,
  output logic             full
);
  localparam int PAD = LEN_W - MPS_W;

  logic [LEN_W-1:0] mps_ext;
  logic             ge_mps;

  always_comb begin
    mps_ext = {{PAD{1'b0}}, mps};
    ge_mps  = (remain >= mps_ext);
    pkt_len = '0;
    zlp     = 1'b0;
    if (active) begin
      pkt_len = ge_mps ? mps : remain[MPS_W-1:0];
      zlp     = (remain == '0);
    end
    last = (remain <= mps_ext);
    full = ge_mps && (remain != '0);
  end
endmodule

// File: rtl/ctrl_rd_counter.sv
module ctrl_rd_counter #(
  parameter int LEN_W = 16,
  parameter int MPS_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] req_len,
  input  logic [LEN_W-1:0] ret_len,
  input  logic [MPS_W-1:0] max_pkt,
  input  logic             consume,
  input  logic [MPS_W-1:0] pkt_len,
  output logic [LEN_W-1:0] remain,
  output logic [MPS_W-1:0] mps,
  output logic             short_ret,
  output logic             eff_zero
);
  localparam int PAD = LEN_W - MPS_W;

  logic [LEN_W-1:0] eff_len;
  logic             ret_below;
  logic [LEN_W-1:0] remain_d;
  logic [MPS_W-1:0] mps_d;
  logic             short_d;
  logic             en;

  always_comb begin
    ret_below = (ret_len < req_len);
    eff_len   = ret_below ? ret_len : req_len;
    eff_zero  = (eff_len == '0);
    en        = load || consume;
    remain_d  = remain;
    mps_d     = mps;
    short_d   = short_ret;
    if (load) begin
      remain_d = eff_len;
      mps_d    = max_pkt;
      short_d  = ret_below;
    end else if (consume) begin
      remain_d = remain - {{PAD{1'b0}}, pkt_len};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain    <= '0;
      mps       <= '0;
      short_ret <= 1'b0;
    end else if (en) begin
      remain    <= remain_d;
      mps       <= mps_d;
      short_ret <= short_d;
    end
  end
endmodule

// File: rtl/ctrl_rd_stage_fsm.sv
module ctrl_rd_stage_fsm
  import ctrl_rd_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   setup_evt,
  input  logic   eff_zero,
  input  logic   in_evt,
  input  logic   in_ack,
  input  logic   out_evt,
  input  logic   out_zero,
  input  logic   zlp,
  input  logic   last,
  input  logic   full,
  input  logic   short_ret,
  output stage_t stage,
  output logic   consume,
  output logic   refill_req,
  output logic   proto_err
);
  stage_t stage_d;
  logic   refill_d;
  logic   err_d;
  logic   ack_data;

  always_comb begin
    stage_d  = stage;
    refill_d = 1'b0;
    err_d    = 1'b0;
    ack_data = !setup_evt && (stage == ST_DATA) && in_evt && in_ack;
    consume  = ack_data;
    if (setup_evt) begin
      stage_d = eff_zero ? ST_STATUS : ST_DATA;
    end else begin
      unique case (stage)
        ST_IDLE: stage_d = ST_IDLE;
        ST_DATA: begin
          if (ack_data) begin
            if (zlp) begin
              stage_d = ST_STATUS;
            end else if (last) begin
              stage_d = (full && short_ret) ? ST_DATA : ST_STATUS;
            end else begin
              refill_d = 1'b1;
            end
          end
        end
        ST_STATUS: begin
          if (in_evt) err_d = 1'b1;
          if (out_evt && out_zero) stage_d = ST_DONE;
        end
        ST_DONE: begin
          if (in_evt) err_d = 1'b1;
        end
        default: stage_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage      <= ST_IDLE;
      refill_req <= 1'b0;
      proto_err  <= 1'b0;
    end else begin
      stage      <= stage_d;
      refill_req <= refill_d;
      proto_err  <= err_d;
    end
  end
endmodule

// File: rtl/ctrl_rd_seq.sv
module ctrl_rd_seq
  import ctrl_rd_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int MPS_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             setup_evt,
  input  logic [LEN_W-1:0] req_len,
  input  logic [LEN_W-1:0] ret_len,
  input  logic [MPS_W-1:0] max_pkt,
  input  logic             in_evt,
  input  logic             in_ack,
  input  logic             out_evt,
  input  logic             out_zero,
  output logic [MPS_W-1:0] pkt_len,
  output logic             zlp,
  output logic             refill_req,
  output logic [1:0]       stage,
  output logic             proto_err
);
  logic             rst_ns;
  logic [LEN_W-1:0] remain;
  logic [MPS_W-1:0] mps;
  logic             short_ret;
  logic             eff_zero;
  logic             consume;
  logic             last;
  logic             full;
  stage_t           stage_q;

  ctrl_rd_rst_sync #(.STAGES(2)) u_rst (
    .clk      (clk),
    .rst_n_in (rst_n),
    .rst_n_out(rst_ns)
  );

  ctrl_rd_counter #(.LEN_W(LEN_W), .MPS_W(MPS_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_ns),
    .load     (setup_evt),
    .req_len  (req_len),
    .ret_len  (ret_len),
    .max_pkt  (max_pkt),
    .consume  (consume),
    .pkt_len  (pkt_len),
    .remain   (remain),
    .mps      (mps),
    .short_ret(short_ret),
    .eff_zero (eff_zero)
  );

  ctrl_rd_pktsize #(.LEN_W(LEN_W), .MPS_W(MPS_W)) u_size (
    .active (stage_q == ST_DATA),
    .remain (remain),
    .mps    (mps),
    .pkt_len(pkt_len),
    .zlp    (zlp),
    .last   (last),
    .full   (full)
  );

  ctrl_rd_stage_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_ns),
    .setup_evt (setup_evt),
    .eff_zero  (eff_zero),
    .in_evt    (in_evt),
    .in_ack    (in_ack),
    .out_evt   (out_evt),
    .out_zero  (out_zero),
    .zlp       (zlp),
    .last      (last),
    .full      (full),
    .short_ret (short_ret),
    .stage     (stage_q),
    .consume   (consume),
    .refill_req(refill_req),
    .proto_err (proto_err)
  );

  assign stage = stage_q;
endmodule

// File: rtl/ctrl_rd_seq_chk.sv
module ctrl_rd_seq_chk #(
  parameter int MPS_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             setup_evt,
  input logic [MPS_W-1:0] max_pkt,
  input logic             in_evt,
  input logic             in_ack,
  input logic             out_evt,
  input logic             out_zero,
  input logic [MPS_W-1:0] pkt_len,
  input logic             zlp,
  input logic             refill_req,
  input logic [1:0]       stage,
  input logic             proto_err
);
  logic [MPS_W-1:0] mps_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mps_seen <= '0;
    else if (setup_evt) mps_seen <= max_pkt;
  end

  a_r2_pkt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (stage == 2'd1) |-> (pkt_len <= mps_seen));

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (stage != 2'd1) |-> (pkt_len == '0 && !zlp));

  a_r4_nak_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (stage == 2'd1 && in_evt && !in_ack && !setup_evt) |=>
      (stage == 2'd1 && $stable(pkt_len) && !refill_req));

  a_r5_refill_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    refill_req |-> $past(in_evt && in_ack && stage == 2'd1));

  a_r7_zlp_empty: assert property (@(posedge clk) disable iff (!rst_n)
    zlp |-> (stage == 2'd1 && pkt_len == '0));

  a_r10_done_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (stage == 2'd3 && $past(stage) != 2'd3) |-> $past(out_evt && out_zero));

  a_r11_restart: assert property (@(posedge clk) disable iff (!rst_n)
    setup_evt |=> (stage == 2'd1 || stage == 2'd2));

  a_r12_late_in: assert property (@(posedge clk) disable iff (!rst_n)
    (in_evt && !setup_evt && (stage == 2'd2 || stage == 2'd3)) |=> proto_err);
endmodule

bind ctrl_rd_seq ctrl_rd_seq_chk #(.MPS_W(MPS_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_ns),
  .setup_evt (setup_evt),
  .max_pkt   (max_pkt),
  .in_evt    (in_evt),
  .in_ack    (in_ack),
  .out_evt   (out_evt),
  .out_zero  (out_zero),
  .pkt_len   (pkt_len),
  .zlp       (zlp),
  .refill_req(refill_req),
  .stage     (stage),
  .proto_err (proto_err)
);

// File: tb/ctrl_rd_seq_tb.sv
module ctrl_rd_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W = 16;
  localparam int MPS_W = 7;

  logic             clk;
  logic             rst_n;
  logic             setup_evt;
  logic [LEN_W-1:0] req_len;
  logic [LEN_W-1:0] ret_len;
  logic [MPS_W-1:0] max_pkt;
  logic             in_evt;
  logic             in_ack;
  logic             out_evt;
  logic             out_zero;
  logic [MPS_W-1:0] pkt_len;
  logic             zlp;
  logic             refill_req;
  logic [1:0]       stage;
  logic             proto_err;

  int n_total;
  int n_fail;

  ctrl_rd_seq #(.LEN_W(LEN_W), .MPS_W(MPS_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .setup_evt(setup_evt), .req_len(req_len),
    .ret_len(ret_len), .max_pkt(max_pkt), .in_evt(in_evt), .in_ack(in_ack),
    .out_evt(out_evt), .out_zero(out_zero), .pkt_len(pkt_len), .zlp(zlp),
    .refill_req(refill_req), .stage(stage), .proto_err(proto_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_total++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send_setup(input int rq, input int rt, input int mp);
    @(negedge clk);
    setup_evt = 1'b1; req_len = LEN_W'(rq); ret_len = LEN_W'(rt); max_pkt = MPS_W'(mp);
    @(negedge clk);
    setup_evt = 1'b0;
  endtask

  task automatic send_in(input logic ack);
    @(negedge clk);
    in_evt = 1'b1; in_ack = ack;
    @(negedge clk);
    in_evt = 1'b0; in_ack = 1'b0;
  endtask

  task automatic send_out(input logic empty);
    @(negedge clk);
    out_evt = 1'b1; out_zero = empty;
    @(negedge clk);
    out_evt = 1'b0; out_zero = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 stage", int'(stage), 0);
    chk("R1 pkt_len", int'(pkt_len), 0);
    chk("R1 zlp", int'(zlp), 0);
    chk("R1 refill", int'(refill_req), 0);
    chk("R1 err", int'(proto_err), 0);
    send_in(1'b1);
    chk("R1 idle IN stage", int'(stage), 0);
  endtask

  task automatic t_short_end();
    send_setup(100, 100, 64);
    chk("R2 stage", int'(stage), 1);
    chk("R2 pkt_len", int'(pkt_len), 64);
    send_in(1'b0);
    chk("R4 nak stage", int'(stage), 1);
    chk("R4 nak pkt_len", int'(pkt_len), 64);
    chk("R4 nak refill", int'(refill_req), 0);
    send_in(1'b1);
    chk("R5 refill", int'(refill_req), 1);
    chk("R5 pkt_len", int'(pkt_len), 36);
    @(negedge clk);
    chk("R5 refill pulse", int'(refill_req), 0);
    send_out(1'b1);
    chk("R10 out in data", int'(stage), 1);
    chk("R10 out in data len", int'(pkt_len), 36);
    send_in(1'b1);
    chk("R6 stage", int'(stage), 2);
    chk("R6 refill", int'(refill_req), 0);
    chk("R1 pkt_len status", int'(pkt_len), 0);
    send_out(1'b0);
    chk("R10 nonempty out", int'(stage), 2);
    send_in(1'b0);
    chk("R12 err status", int'(proto_err), 1);
    chk("R12 stage status", int'(stage), 2);
    send_out(1'b1);
    chk("R10 done", int'(stage), 3);
    send_in(1'b1);
    chk("R12 err done", int'(proto_err), 1);
    chk("R12 stage done", int'(stage), 3);
    @(negedge clk);
    chk("R12 err pulse", int'(proto_err), 0);
  endtask

  task automatic t_zlp();
    send_setup(200, 128, 64);
    chk("R11 from done", int'(stage), 1);
    send_in(1'b1);
    chk("R7 second len", int'(pkt_len), 64);
    send_in(1'b1);
    chk("R7 zlp flag", int'(zlp), 1);
    chk("R7 zlp len", int'(pkt_len), 0);
    chk("R7 zlp stage", int'(stage), 1);
    chk("R7 no refill", int'(refill_req), 0);
    send_in(1'b1);
    chk("R7 after zlp", int'(stage), 2);
    chk("R7 zlp clear", int'(zlp), 0);
  endtask

  task automatic t_exact();
    send_setup(128, 128, 64);
    chk("R11 from status", int'(stage), 1);
    send_in(1'b1);
    send_in(1'b1);
    chk("R8 stage", int'(stage), 2);
    chk("R8 zlp", int'(zlp), 0);
  endtask

  task automatic t_clamp();
    send_setup(10, 50, 64);
    chk("R3 clamp len", int'(pkt_len), 10);
    send_in(1'b1);
    chk("R3 clamp end", int'(stage), 2);
    send_setup(40, 20, 8);
    chk("R3 ret smaller", int'(pkt_len), 8);
    send_in(1'b1);
    send_in(1'b1);
    chk("R3 ret tail", int'(pkt_len), 4);
  endtask

  task automatic t_zero();
    send_setup(20, 0, 64);
    chk("R9 stage", int'(stage), 2);
    chk("R9 zlp", int'(zlp), 0);
    send_out(1'b1);
    chk("R9 done", int'(stage), 3);
  endtask

  task automatic t_abort();
    send_setup(300, 300, 64);
    send_in(1'b1);
    chk("R11 mid len", int'(pkt_len), 64);
    send_setup(30, 30, 8);
    chk("R11 restart stage", int'(stage), 1);
    chk("R11 restart len", int'(pkt_len), 8);
    chk("R11 restart refill", int'(refill_req), 0);
    send_in(1'b1); send_in(1'b1); send_in(1'b1);
    chk("R11 new tail", int'(pkt_len), 6);
    send_in(1'b1);
    chk("R11 new end", int'(stage), 2);
  endtask

  initial begin
    n_total = 0; n_fail = 0;
    setup_evt = 1'b0; req_len = '0; ret_len = '0; max_pkt = '0;
    in_evt = 1'b0; in_ack = 1'b0; out_evt = 1'b0; out_zero = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 stage in reset", int'(stage), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_short_end();
    t_zlp();
    t_exact();
    t_clamp();
    t_zero();
    t_abort();
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_total++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule